// File: doc/BRIEF.md
# Paged Hardware Stack Engine

This block runs a processor stack that lives in a single fixed page of a byte-addressed memory with a 16-bit address space. It holds an 8-bit stack pointer and turns push and pop requests into accesses on a synchronous single-port byte RAM. Requests move either one byte or two. The two-byte form carries return addresses and the saved status byte. A subroutine call pushes the program counter that already points past the operand bytes, and a return takes the popped value as it is.

The pointer can be loaded from an index register. A load also produces negative and zero flags from the value that was transferred. The current pointer is always visible on an output port.

After reset the block zeroes the bottom of its stack page, one byte per cycle, and reports busy while it does so. Two-byte transfers also take two memory cycles and report busy for that time. Any request that arrives while the block is busy is dropped.

Top module: `stack_engine`

## Requirements
- R1: Every stack access uses the address 0x0100 plus the 8-bit pointer: high byte 0x01, low byte the pointer. No cycle has both a read and a write.
- R2: While reset is high, the pointer is 0xFF, both flags are 0 and pop_valid is 0.
- R3: A byte push (req_op 1) writes req_data[7:0] at the current pointer address and then decrements the pointer.
- R4: A byte pop (req_op 2) reads at the current pointer address and increments the pointer. pop_valid is high for one cycle, two clock edges after the accepting edge, with the byte in pop_data[7:0] and zeros in pop_data[15:8].
- R5: A two-byte push (req_op 3) writes req_data[15:8] at the pointer and then req_data[7:0] at the pointer minus one. The pointer ends two lower, so the low byte sits at the lower address.
- R6: A two-byte pop (req_op 4) reads the low byte at the pointer and the high byte at the pointer plus one. The pointer ends two higher. pop_data is {high, low}, unadjusted, and is valid three edges after the accepting edge.
- R7: Once reset is released, the block writes zero to the 254 bytes from 0x0100 through 0x01FD, one per cycle, and holds busy high for exactly those 254 cycles. 0x01FE and 0x01FF are left untouched.
- R8: The pointer wraps modulo 256 in both directions and no error is raised. A two-byte pop at pointer 0xFF takes its high byte from 0x0100.
- R9: busy is high during the clear and during the extra cycles of any operation. A request (req_valid high) seen while busy has no effect on memory or on the pointer.
- R10: A pointer load (req_op 5) places idx_in in the pointer on the next edge. It sets flag_n to bit 7 of idx_in and sets flag_z when idx_in is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation: 0 none, 1 byte push, 2 byte pop, 3 two-byte push, 4 two-byte pop, 5 pointer load |
| req_data | input | 16 | Value to push |
| idx_in | input | 8 | Index register value for a pointer load |
| busy | output | 1 | Block cannot accept a request |
| sp_out | output | 8 | Current stack pointer |
| flag_n | output | 1 | Negative flag from the last pointer load |
| flag_z | output | 1 | Zero flag from the last pointer load |
| pop_valid | output | 1 | One-cycle strobe for pop_data |
| pop_data | output | 16 | Popped value |
| mem_addr | output | 16 | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid the cycle after the read |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, page 0x01, 254 cleared bytes and 0xFF as the reset pointer. With these values a pointer load can place the pointer at 0x00 or 0xFF, so both wrap directions are reached with a few requests. That includes a two-byte pop whose bytes straddle the ends of the page. The full-length clear can also be timed cycle by cycle and checked against its two untouched top bytes.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PUSH8  = 3'd1,
        OP_POP8   = 3'd2,
        OP_PUSH16 = 3'd3,
        OP_POP16  = 3'd4,
        OP_LDSP   = 3'd5
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_PUSH_LO,
        ST_POP_HI,
        ST_CAP8,
        ST_CAP16
    } stk_state_e;

    typedef struct packed {
        logic       we;
        logic       re;
        logic [7:0] off;
        logic [7:0] wdata;
    } mem_cmd_t;

    typedef struct packed {
        logic dec;
        logic inc;
        logic load;
    } sp_ctl_t;

    function automatic logic [15:0] page_addr(input logic [7:0] page, input logic [7:0] off);
        return {page, off};
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter int          SP_W    = 8,
    parameter logic [7:0]  SP_INIT = 8'hFF
) (
    input  logic            clk,
    input  logic            rst,
    input  sp_ctl_t         ctl,
    input  logic [SP_W-1:0] load_val,
    output logic [SP_W-1:0] sp,
    output logic            flag_n,
    output logic            flag_z
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp     <= SP_W'(SP_INIT);
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (ctl.load) begin
            sp     <= load_val;
            flag_n <= load_val[SP_W-1];
            flag_z <= (load_val == '0);
        end else if (ctl.dec) begin
            sp <= sp - 1'b1;
        end else if (ctl.inc) begin
            sp <= sp + 1'b1;
        end
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter int SP_W      = 8,
    parameter int DATA_W    = 8,
    parameter int CLR_BYTES = 254
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [2*DATA_W-1:0] req_data,
    input  logic [SP_W-1:0]   sp,
    input  logic [DATA_W-1:0] mem_rdata,
    output mem_cmd_t          cmd,
    output sp_ctl_t           ctl,
    output logic              busy,
    output logic              pop_valid,
    output logic [2*DATA_W-1:0] pop_data
);

    localparam int CNT_W = $clog2(CLR_BYTES + 1);

    stk_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] lo_q;
    stk_op_e           op;

    assign op   = stk_op_e'(req_op);
    assign busy = (state != ST_IDLE);

    always_comb begin
        cmd      = '0;
        ctl      = '0;
        cmd.off  = 8'(sp);
        case (state)
            ST_CLEAR: begin
                cmd.we  = 1'b1;
                cmd.off = 8'(cnt);
            end
            ST_IDLE: if (req_valid) begin
                case (op)
                    OP_PUSH8:  begin cmd.we = 1'b1; cmd.wdata = req_data[DATA_W-1:0]; ctl.dec = 1'b1; end
                    OP_PUSH16: begin cmd.we = 1'b1; cmd.wdata = req_data[2*DATA_W-1:DATA_W]; ctl.dec = 1'b1; end
                    OP_POP8,
                    OP_POP16:  begin cmd.re = 1'b1; ctl.inc = 1'b1; end
                    OP_LDSP:   ctl.load = 1'b1;
                    default: ;
                endcase
            end
            ST_PUSH_LO: begin cmd.we = 1'b1; cmd.wdata = lo_q; ctl.dec = 1'b1; end
            ST_POP_HI:  begin cmd.re = 1'b1; ctl.inc = 1'b1; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CLEAR;
            cnt       <= '0;
            lo_q      <= '0;
            pop_valid <= 1'b0;
            pop_data  <= '0;
        end else begin
            pop_valid <= 1'b0;
            case (state)
                ST_CLEAR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(CLR_BYTES - 1)) state <= ST_IDLE;
                end
                ST_IDLE: if (req_valid) begin
                    case (op)
                        OP_PUSH16: begin lo_q <= req_data[DATA_W-1:0]; state <= ST_PUSH_LO; end
                        OP_POP8:   state <= ST_CAP8;
                        OP_POP16:  state <= ST_POP_HI;
                        default: ;
                    endcase
                end
                ST_PUSH_LO: state <= ST_IDLE;
                ST_POP_HI: begin
                    lo_q  <= mem_rdata;
                    state <= ST_CAP16;
                end
                ST_CAP8: begin
                    pop_data  <= {{DATA_W{1'b0}}, mem_rdata};
                    pop_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                ST_CAP16: begin
                    pop_data  <= {mem_rdata, lo_q};
                    pop_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CLEAR && cmd.we) |=> (sp == $past(sp) - 1'b1)); // R3
    AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
        cmd.re |=> (sp == $past(sp) + 1'b1)); // R4
    AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAP8 || state == ST_CAP16) |=> $stable(sp)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        pop_valid |=> !pop_valid); // R4

endmodule

// File: rtl/stack_engine.sv
module stack_engine
    import stk_pkg::*;
#(
    parameter int         SP_W      = 8,
    parameter int         PAGE_W    = 8,
    parameter int         DATA_W    = 8,
    parameter logic [7:0] PAGE      = 8'h01,
    parameter logic [7:0] SP_INIT   = 8'hFF,
    parameter int         CLR_BYTES = 254
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [2*DATA_W-1:0]      req_data,
    input  logic [SP_W-1:0]          idx_in,
    output logic                     busy,
    output logic [SP_W-1:0]          sp_out,
    output logic                     flag_n,
    output logic                     flag_z,
    output logic                     pop_valid,
    output logic [2*DATA_W-1:0]      pop_data,
    output logic [PAGE_W+SP_W-1:0]   mem_addr,
    output logic                     mem_we,
    output logic                     mem_re,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata
);

    localparam int ADDR_W = PAGE_W + SP_W;

    mem_cmd_t cmd;
    sp_ctl_t  ctl;

    stk_ptr #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_ptr (
        .clk(clk), .rst(rst), .ctl(ctl), .load_val(idx_in),
        .sp(sp_out), .flag_n(flag_n), .flag_z(flag_z)
    );

    stk_seq #(.SP_W(SP_W), .DATA_W(DATA_W), .CLR_BYTES(CLR_BYTES)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .sp(sp_out), .mem_rdata(mem_rdata),
        .cmd(cmd), .ctl(ctl), .busy(busy),
        .pop_valid(pop_valid), .pop_data(pop_data)
    );

    assign mem_addr  = ADDR_W'(page_addr(PAGE, cmd.off));
    assign mem_we    = cmd.we;
    assign mem_re    = cmd.re;
    assign mem_wdata = DATA_W'(cmd.wdata);

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:SP_W] == PAGE_W'(PAGE))); // R1
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R1
    AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_op == OP_LDSP) |=> (sp_out == $past(idx_in))); // R10

endmodule

// File: tb/tb_stack_engine.sv
module tb_stack_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_data = 16'h0;
    logic [7:0]  idx_in = 8'h0;
    logic        busy, flag_n, flag_z, pop_valid, mem_we, mem_re;
    logic [7:0]  sp_out, mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic [15:0] pop_data, mem_addr;

    logic [7:0]  ram [0:511];
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    stack_engine dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .idx_in(idx_in), .busy(busy), .sp_out(sp_out),
        .flag_n(flag_n), .flag_z(flag_z), .pop_valid(pop_valid),
        .pop_data(pop_data), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[8:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[8:0]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference of the page address (R1)
    always @(negedge clk) begin
        if (!rst && !done && (mem_we || mem_re)) begin
            check("R1 page", {16'h0, mem_addr[15:8]}, 32'h01);
            check("R1 single access", {31'h0, mem_we & mem_re}, 32'h0);
        end
    end

    task automatic op(input logic [2:0] o, input logic [15:0] d, input logic [7:0] ix);
        req_valid = 1'b1; req_op = o; req_data = d; idx_in = ix;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        bit zero_ok;
        for (int i = 0; i < 512; i++) ram[i] = 8'hAA;
        repeat (3) @(negedge clk);
        check("R2 sp", {24'h0, sp_out}, 32'hFF);
        check("R2 flags", {30'h0, flag_n, flag_z}, 32'h0);
        check("R2 pop_valid", {31'h0, pop_valid}, 32'h0);
        rst = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            if (cyc == 10) begin req_valid = 1'b1; req_op = 3'd1; req_data = 16'h0055; end
            if (cyc == 11) begin req_valid = 1'b0; req_op = 3'd0; end
            @(negedge clk);
        end
        check("R7 clear cycles", cyc, 254);
        zero_ok = 1;
        for (int a = 9'h100; a <= 9'h1FD; a++) if (ram[a] !== 8'h00) zero_ok = 0;
        check("R7 cleared range", {31'h0, zero_ok}, 32'h1);
        check("R7 top byte FE", {24'h0, ram[9'h1FE]}, 32'hAA);
        check("R9 push during clear ignored", {24'h0, ram[9'h1FF]}, 32'hAA);
        check("R9 sp after clear", {24'h0, sp_out}, 32'hFF);

        op(3'd1, 16'h005A, 8'h0);
        check("R3 byte at 1FF", {24'h0, ram[9'h1FF]}, 32'h5A);
        check("R3 sp", {24'h0, sp_out}, 32'hFE);

        op(3'd3, 16'h1234, 8'h0);
        check("R5 high at 1FE", {24'h0, ram[9'h1FE]}, 32'h12);
        check("R5 low at 1FD", {24'h0, ram[9'h1FD]}, 32'h34);
        check("R5 sp", {24'h0, sp_out}, 32'hFC);

        ram[9'h1FC] = 8'h77;
        op(3'd2, 16'h0, 8'h0);
        check("R4 pop_valid", {31'h0, pop_valid}, 32'h1);
        check("R4 pop_data", {16'h0, pop_data}, 32'h0077);
        check("R4 sp", {24'h0, sp_out}, 32'hFD);
        @(negedge clk);
        check("R4 pulse one cycle", {31'h0, pop_valid}, 32'h0);

        req_valid = 1'b1; req_op = 3'd4;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        check("R9 busy pop16 first", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check("R9 busy pop16 second", {31'h0, busy}, 32'h1);
        @(negedge clk);
        check("R6 pop_valid", {31'h0, pop_valid}, 32'h1);
        check("R6 pop_data", {16'h0, pop_data}, 32'h1234);
        check("R6 sp", {24'h0, sp_out}, 32'hFF);

        req_valid = 1'b1; req_op = 3'd5; idx_in = 8'h80;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        check("R10 sp load", {24'h0, sp_out}, 32'h80);
        check("R10 flags 80", {30'h0, flag_n, flag_z}, 32'h2);

        op(3'd5, 16'h0, 8'h00);
        check("R10 flags 00", {30'h0, flag_n, flag_z}, 32'h1);
        op(3'd1, 16'h00C3, 8'h0);
        check("R8 push at 100", {24'h0, ram[9'h100]}, 32'hC3);
        check("R8 sp wraps down", {24'h0, sp_out}, 32'hFF);
        op(3'd2, 16'h0, 8'h0);
        check("R8 pop at 1FF", {16'h0, pop_data}, 32'h005A);
        check("R8 sp wraps up", {24'h0, sp_out}, 32'h00);

        req_valid = 1'b1; req_op = 3'd3; req_data = 16'hBEEF;
        @(negedge clk);
        req_op = 3'd1; req_data = 16'h0011;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        while (busy) @(negedge clk);
        check("R9 high at 100", {24'h0, ram[9'h100]}, 32'hBE);
        check("R9 low at 1FF", {24'h0, ram[9'h1FF]}, 32'hEF);
        check("R9 ignored push", {24'h0, ram[9'h1FE]}, 32'h12);
        check("R9 sp", {24'h0, sp_out}, 32'hFE);

        op(3'd5, 16'h0, 8'hFF);
        op(3'd4, 16'h0, 8'h0);
        check("R8 pop16 across page ends", {16'h0, pop_data}, 32'hBEEF);
        check("R8 sp after pop16", {24'h0, sp_out}, 32'h01);

        ram[9'h101] = 8'hFF; ram[9'h102] = 8'h0F;
        op(3'd4, 16'h0, 8'h0);
        check("R6 unadjusted value", {16'h0, pop_data}, 32'h0FFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule